// File: doc/BRIEF.md
# Host Interrupt Aggregator with Masking

This block gathers single-cycle event pulses from sixteen internal sources into one interrupt line toward a host processor. Each pulse sets a sticky pending bit. A mask register decides which pending bits may reach the line. The line is registered and can be driven active-high or active-low.

The host reaches the block through a small register bus. Each access takes one cycle and has an address, a write strobe, a read strobe, write data and registered read data. The mask can be written whole, or changed bit by bit through separate write-one set and write-one clear ports, so the host never has to read the mask, modify it and write it back. Pending status can be read in two ways. One read has no side effect. The other read returns the pending bits and clears them all. A write-one acknowledge port clears chosen bits only. A clear and a new pulse on the same bit in the same cycle always leave that bit pending, so no event is lost.

Top module: `irq_agg_top`

## Requirements
- R1: After synchronous reset the mask is 0x0001, every pending bit is 0, the active-low setting is 0, `host_irq_o` is 0 and `rdata_o` is 0.
- R2: Address 0 is the full mask, readable and writable. A 1 in a mask bit stops that source from reaching the interrupt line, and a 0 lets it through.
- R3: Writing address 1 sets the mask bits that are written as 1. Bits written as 0 leave their mask bits unchanged.
- R4: Writing address 2 clears the mask bits that are written as 1. Bits written as 0 leave their mask bits unchanged.
- R5: Reading address 3 returns the pending bits and changes none of them.
- R6: Reading address 4 returns the pending bits as they were before the read, then clears every pending bit.
- R7: Writing address 5 clears each pending bit written as 1. Bits written as 0 stay as they are.
- R8: When an event pulse on a source arrives in the same cycle as a clear of that bit, the bit stays pending. The clear can come from an acknowledge write or from a clear-on-read.
- R9: A pulse sets its pending bit whether or not the source is masked. One cycle after the pending and mask registers settle, `host_irq_o` shows the OR of the pending bits whose mask bits are 0.
- R10: Bit 0 of address 6 is a readable and writable active-low setting. When it is 1, `host_irq_o` is inverted, with the same one-cycle lag.
- R11: Read data appears on `rdata_o` in the cycle after `rd_en_i` and holds until the next read. Addresses 1, 2, 5 and 7 and above read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | NUM_SRC | One-cycle event pulses, one per source |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | NUM_SRC | Write data |
| rdata_o | output | NUM_SRC | Registered read data |
| host_irq_o | output | 1 | Registered host interrupt line |

## Verification
The bench builds the block with its default parameters: sixteen sources, a four-bit address and a reset mask of 0x0001. With these values every address, including the unused ones from 7 to 15, is in reach. Source 0 starts out masked, so the first pulses show a bit that is pending while the line stays quiet. Directed steps cover pulses that collide with an acknowledge and with a clear-on-read. A long random stretch then mixes writes and reads to all sixteen addresses with sparse pulses. On every clock, the line and the read data are compared against a behavioural model.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  // register offsets; the bench and checker rely on these values
  localparam int OFS_MASK   = 0;
  localparam int OFS_SET    = 1;
  localparam int OFS_CLR    = 2;
  localparam int OFS_PEEK   = 3;
  localparam int OFS_RCLR   = 4;
  localparam int OFS_ACK    = 5;
  localparam int OFS_CFG    = 6;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MASK,
    SEL_SET,
    SEL_CLR,
    SEL_PEEK,
    SEL_RCLR,
    SEL_ACK,
    SEL_CFG
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input int a);
    case (a)
      OFS_MASK: return SEL_MASK;
      OFS_SET:  return SEL_SET;
      OFS_CLR:  return SEL_CLR;
      OFS_PEEK: return SEL_PEEK;
      OFS_RCLR: return SEL_RCLR;
      OFS_ACK:  return SEL_ACK;
      OFS_CFG:  return SEL_CFG;
      default:  return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
#(
  parameter int          NUM_SRC    = 16,
  parameter logic [NUM_SRC-1:0] MASK_RESET = 'h1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  reg_sel_e           sel,
  input  logic [NUM_SRC-1:0] wdata,
  output logic [NUM_SRC-1:0] mask_q,
  output logic               act_low_q
);
  logic [NUM_SRC-1:0] mask_n;

  always_comb begin
    mask_n = mask_q;
    if (wr_en) begin
      case (sel)
        SEL_MASK: mask_n = wdata;
        SEL_SET:  mask_n = mask_q | wdata;
        SEL_CLR:  mask_n = mask_q & ~wdata;
        default:  mask_n = mask_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q    <= MASK_RESET;
      act_low_q <= 1'b0;
    end else begin
      mask_q <= mask_n;
      if (wr_en && sel == SEL_CFG) act_low_q <= wdata[0];
    end
  end
endmodule

// File: rtl/irq_agg_pend.sv
module irq_agg_pend #(
  parameter int NUM_SRC = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] evt,
  input  logic               ack_en,
  input  logic [NUM_SRC-1:0] ack_bits,
  input  logic               rclr_en,
  output logic [NUM_SRC-1:0] pend_q
);
  logic [NUM_SRC-1:0] clr_bits;

  always_comb begin
    clr_bits = '0;
    if (ack_en)  clr_bits = clr_bits | ack_bits;
    if (rclr_en) clr_bits = '1;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)         pend_q[i] <= 1'b0;
      else if (evt[i]) pend_q[i] <= 1'b1;   // a new pulse beats any clear
      else if (clr_bits[i]) pend_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_agg_line.sv
module irq_agg_line #(
  parameter int NUM_SRC = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] pend,
  input  logic [NUM_SRC-1:0] mask,
  input  logic               act_low,
  output logic               irq_q
);
  logic any_live;
  assign any_live = |(pend & ~mask);

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= any_live ^ act_low;
  end
endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
  import irq_agg_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int ADDR_W  = 4,
  parameter logic [NUM_SRC-1:0] MASK_RESET = 'h1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] rdata_o,
  output logic               host_irq_o
);
  localparam int CFG_PAD = NUM_SRC - 1;

  reg_sel_e           sel;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] pend_q;
  logic               act_low_q;
  logic [NUM_SRC-1:0] rd_mux;

  assign sel = decode_addr(int'(addr_i));

  irq_agg_ctrl #(.NUM_SRC(NUM_SRC), .MASK_RESET(MASK_RESET)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en_i),
    .sel       (sel),
    .wdata     (wdata_i),
    .mask_q    (mask_q),
    .act_low_q (act_low_q)
  );

  irq_agg_pend #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk      (clk),
    .rst      (rst),
    .evt      (evt_i),
    .ack_en   (wr_en_i && sel == SEL_ACK),
    .ack_bits (wdata_i),
    .rclr_en  (rd_en_i && sel == SEL_RCLR),
    .pend_q   (pend_q)
  );

  irq_agg_line #(.NUM_SRC(NUM_SRC)) u_line (
    .clk     (clk),
    .rst     (rst),
    .pend    (pend_q),
    .mask    (mask_q),
    .act_low (act_low_q),
    .irq_q   (host_irq_o)
  );

  always_comb begin
    case (sel)
      SEL_MASK: rd_mux = mask_q;
      SEL_PEEK: rd_mux = pend_q;
      SEL_RCLR: rd_mux = pend_q;
      SEL_CFG:  rd_mux = {{CFG_PAD{1'b0}}, act_low_q};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_mux;
  end
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
  import irq_agg_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int ADDR_W  = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] evt_i,
  input logic               wr_en_i,
  input logic               rd_en_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [NUM_SRC-1:0] wdata_i,
  input logic [NUM_SRC-1:0] mask_q,
  input logic [NUM_SRC-1:0] pend_q,
  input logic               act_low_q,
  input logic               host_irq_o
);
  logic is_set, is_clr, is_ack, is_peek, is_rclr;
  assign is_set  = wr_en_i && int'(addr_i) == OFS_SET;
  assign is_clr  = wr_en_i && int'(addr_i) == OFS_CLR;
  assign is_ack  = wr_en_i && int'(addr_i) == OFS_ACK;
  assign is_peek = rd_en_i && int'(addr_i) == OFS_PEEK;
  assign is_rclr = rd_en_i && int'(addr_i) == OFS_RCLR;

  assert_mask_set_R3: assert property (@(posedge clk) disable iff (rst)
    is_set |=> mask_q == ($past(mask_q) | $past(wdata_i)));

  assert_mask_clr_R4: assert property (@(posedge clk) disable iff (rst)
    is_clr |=> mask_q == ($past(mask_q) & ~$past(wdata_i)));

  assert_peek_keeps_R5: assert property (@(posedge clk) disable iff (rst)
    (is_peek && !wr_en_i) |=> pend_q == ($past(pend_q) | $past(evt_i)));

  assert_rclr_empties_R6: assert property (@(posedge clk) disable iff (rst)
    is_rclr |=> pend_q == $past(evt_i));

  assert_ack_bits_R7: assert property (@(posedge clk) disable iff (rst)
    (is_ack && !rd_en_i) |=> pend_q == (($past(pend_q) & ~$past(wdata_i)) | $past(evt_i)));

  assert_event_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (evt_i != '0) |=> (pend_q & $past(evt_i)) == $past(evt_i));

  assert_line_R9: assert property (@(posedge clk) disable iff (rst)
    (!act_low_q && $stable(act_low_q)) |=> host_irq_o == (|($past(pend_q) & ~$past(mask_q))));

  assert_polarity_R10: assert property (@(posedge clk) disable iff (rst)
    (act_low_q && $stable(act_low_q)) |=> host_irq_o == !(|($past(pend_q) & ~$past(mask_q))));
endmodule

bind irq_agg_top irq_agg_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .evt_i      (evt_i),
  .wr_en_i    (wr_en_i),
  .rd_en_i    (rd_en_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .mask_q     (mask_q),
  .pend_q     (pend_q),
  .act_low_q  (act_low_q),
  .host_irq_o (host_irq_o)
);

// File: tb/tb_irq_agg_top.sv
module tb_irq_agg_top;
  localparam int N  = 16;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  evt = '0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [N-1:0]  wdata = '0;
  logic [N-1:0]  rdata;
  logic          irq;

  int checks = 0;
  int fails  = 0;
  bit compare_on = 1'b0;

  always #2.5 clk = ~clk;

  irq_agg_top #(.NUM_SRC(N), .ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .evt_i(evt), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .host_irq_o(irq)
  );

  // behavioural reference model
  int unsigned m_mask, m_pend, m_rd;
  bit          m_al, m_irq;

  always @(posedge clk) begin
    int unsigned nm, np, nr;
    bit na, ni;
    if (rst) begin
      m_mask = 32'h1; m_pend = 0; m_rd = 0; m_al = 0; m_irq = 0;
    end else begin
      nm = m_mask; np = m_pend; nr = m_rd; na = m_al;
      ni = ((m_pend & ~m_mask & 32'hFFFF) != 0) ^ m_al;
      if (rd_en) begin
        case (int'(addr))
          0: nr = m_mask;
          3, 4: nr = m_pend;
          6: nr = m_al;
          default: nr = 0;
        endcase
        if (addr == 4) np = 0;
      end
      if (wr_en) begin
        case (int'(addr))
          0: nm = wdata;
          1: nm = m_mask | wdata;
          2: nm = m_mask & ~wdata;
          5: np = np & ~wdata;
          6: na = wdata[0];
          default: ;
        endcase
      end
      np = np | evt;
      m_mask = nm & 32'hFFFF; m_pend = np & 32'hFFFF; m_rd = nr; m_al = na; m_irq = ni;
    end
  end

  task automatic check(string tag, int unsigned act, int unsigned exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (compare_on) begin
      check("R9/R10 cycle host_irq_o", irq, m_irq);
      check("R11 cycle rdata_o", rdata, m_rd);
    end
  end

  task automatic idle(int n = 1);
    repeat (n) begin
      @(negedge clk);
      wr_en = 0; rd_en = 0; evt = '0;
    end
  endtask

  task automatic op(bit w, bit r, int a, int unsigned d, int unsigned e);
    @(negedge clk);
    wr_en = w; rd_en = r; addr = AW'(a); wdata = N'(d); evt = N'(e);
  endtask

  task automatic rd_expect(int a, int unsigned exp, string tag);
    op(0, 1, a, 0, 0);
    @(negedge clk);
    rd_en = 0;
    check(tag, rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    compare_on = 1;
    // R1 reset state
    check("R1 irq after reset", irq, 0);
    check("R1 rdata after reset", rdata, 0);
    rd_expect(0, 16'h0001, "R1 mask reset value");
    rd_expect(3, 0, "R1 pending empty");
    rd_expect(6, 0, "R1 active-low off");

    // R9 masked source still latches, line stays quiet
    op(0, 0, 0, 0, 16'h0001); idle(3);
    check("R9 masked source no irq", irq, 0);
    rd_expect(3, 16'h0001, "R9 masked pulse latched");
    op(0, 0, 0, 0, 16'h0008); idle(2);
    check("R9 unmasked source raises irq", irq, 1);

    // R3 set port
    op(1, 0, 1, 16'h0008, 0); idle(2);
    check("R3 set masks source 3", irq, 0);
    rd_expect(0, 16'h0009, "R3 mask after set");
    // R4 clear port
    op(1, 0, 2, 16'h0001, 0); idle(2);
    rd_expect(0, 16'h0008, "R4 mask after clear");
    check("R4 source 0 unmasked raises irq", irq, 1);
    // R2 full mask write
    op(1, 0, 0, 16'h00F0, 0); idle(1);
    rd_expect(0, 16'h00F0, "R2 mask readback");
    op(1, 0, 0, 16'hFFFF, 0); idle(2);
    check("R2 all masked no irq", irq, 0);
    op(1, 0, 0, 16'h0000, 0); idle(2);

    // R7 acknowledge
    op(1, 0, 5, 16'h0001, 0); idle(1);
    rd_expect(3, 16'h0008, "R7 ack clears only bit 0");
    // R5 peek twice
    rd_expect(3, 16'h0008, "R5 peek unchanged");
    // R6 clear on read
    op(0, 0, 0, 0, 16'h0300); idle(1);
    rd_expect(4, 16'h0308, "R6 read-clear returns pending");
    rd_expect(3, 0, "R6 pending cleared");
    idle(2);
    check("R6 irq drops after clear", irq, 0);

    // R8 collisions
    op(0, 0, 0, 0, 16'h0002); idle(1);
    op(1, 0, 5, 16'h0002, 16'h0002); idle(1);
    rd_expect(3, 16'h0002, "R8 pulse beats ack");
    op(0, 1, 4, 0, 16'h0004); idle(1);
    check("R8 read-clear returns old value", rdata, 16'h0002);
    rd_expect(3, 16'h0004, "R8 pulse beats read-clear");

    // R10 active-low
    op(1, 0, 6, 16'h0001, 0); idle(2);
    check("R10 active-low asserted is 0", irq, 0);
    rd_expect(6, 1, "R10 config readback");
    op(1, 0, 5, 16'hFFFF, 0); idle(2);
    check("R10 active-low idle is 1", irq, 1);
    op(1, 0, 6, 0, 0); idle(2);

    // R11 write-only and unused reads, hold
    rd_expect(1, 0, "R11 set port reads 0");
    rd_expect(9, 0, "R11 unused address reads 0");
    rd_expect(0, 16'h0000, "R11 mask read");
    op(1, 0, 0, 16'h1234, 0); idle(2);
    check("R11 rdata holds without read", rdata, 0);

    // random mix, compared every clock
    for (int i = 0; i < 2000; i++) begin
      int unsigned r = $urandom;
      op(r[0], r[1], int'(r[5:2]), $urandom & 16'hFFFF,
         (r[8:6] == 0) ? ($urandom & 16'hFFFF) : 0);
    end
    idle(3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule